// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a serial management master that runs one read or one write transaction at a time against an external transceiver. It uses a clock it generates itself (MDC) and a single bidirectional data line (MDIO). The surrounding logic presents a command with these fields: an operation type, a 5-bit transceiver address, a 5-bit register address and, for writes, a 16-bit data word. The engine serialises the frame, drives the shared line through separate output-enable and output-value pins, and reports completion with a one-cycle done pulse.

MDC is produced from the system clock. Each of its half periods lasts `HALF` system clocks, and the clock toggles only while a transaction is running. A read does not sample at a fixed turnaround point. The engine releases the line for one bit, then hunts for the zero bit that the transceiver drives, and captures the 16 bits that follow. If that zero bit never appears within `WAIT_MAX` bit times, the read ends with an error flag and a data value of all ones.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 consecutive one bits driven on MDIO. These are MDC rising edges 1 to 32 of the transaction.
- R2: Edges 33 and 34 carry the start pattern 0, 1. Edges 35 and 36 carry the opcode: 0, 1 for a write and 1, 0 for a read (`cmd_read`=1).
- R3: Edges 37 to 41 carry the transceiver address and edges 42 to 46 carry the register address, each sent most significant bit first.
- R4: For a write, edges 47 and 48 carry 1, 0 and edges 49 to 64 carry the write data MSB first. The line is then released and `done` pulses. A write has exactly 64 MDC rising edges.
- R5: For a read, the engine drives MDIO on edges 1 to 46 only and leaves it undriven from edge 47 onwards. Edge 47 is never sampled.
- R6: From edge 48 the engine samples MDIO on each rising edge. The first sampled zero locks the frame, and the next 16 samples, MSB first, become `rd_data` with `rd_err`=0. A zero at edge 48+d gives a total of 64+d edges.
- R7: If the samples at edges 48 to 48+WAIT_MAX-1 are all one, the read ends after edge 48+WAIT_MAX-1 with `rd_err`=1 and `rd_data`=16'hFFFF.
- R8: `mdio_o` and `mdio_oe` change only while MDC is low. Each MDC half period lasts `HALF` system clocks, and MDC rests low when idle.
- R9: `busy` is high from the cycle after a command is accepted until `done`. A `cmd_valid` seen while busy is ignored: the running frame is unchanged and only one `done` results.
- R10: While idle, the engine does not drive MDIO. It never drives the line while the transceiver drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a transaction (taken when idle) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | Transceiver address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Read timed out waiting for the zero bit |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Drive enable for MDIO |
| mdio_o | output | 1 | Value driven on MDIO |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The assertions check on every cycle the following rules. The line is quiet and MDC rests low when idle. The drive pins never change while MDC is high. `busy` holds until `done`, and `done` falls with `busy`. A timed-out read always returns all ones. Only the bench scenarios can show that the frame content is correct bit by bit, that the lock point is right for every transceiver delay up to and past the limit, that the edge counts are correct, and that a command arriving mid-frame leaves the frame untouched.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF     = 2,
  parameter int WAIT_MAX = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_oe,
  output logic        mdio_o,
  input  logic        mdio_i
);
  localparam int CW = $clog2(HALF) + 1;
  localparam int HW = $clog2(WAIT_MAX) + 1;

  typedef enum logic [2:0] {IDLE, SEND, RELZ, HUNT, CAPT, FIN} ph_t;
  ph_t            ph;
  logic [CW-1:0]  cnt;
  logic [63:0]    sh;
  logic [6:0]     left;
  logic [HW-1:0]  hunt;
  logic           is_rd;

  wire tick = (ph != IDLE) && (cnt == CW'(HALF - 1));
  wire rise = tick & ~mdc;
  wire fall = tick & mdc;

  wire [63:0] frame = cmd_read
    ? {32'hFFFF_FFFF, 2'b01, 2'b10, cmd_phy, cmd_reg, 18'd0}
    : {32'hFFFF_FFFF, 2'b01, 2'b01, cmd_phy, cmd_reg, 2'b10, cmd_wdata};

  assign busy = (ph != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE; cnt <= '0; sh <= '0; left <= '0; hunt <= '0; is_rd <= 1'b0;
      done <= 1'b0; rd_data <= '0; rd_err <= 1'b0;
      mdc <= 1'b0; mdio_oe <= 1'b0; mdio_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == IDLE) begin
        mdc <= 1'b0;
        cnt <= '0;
        if (cmd_valid) begin
          ph      <= SEND;
          sh      <= frame;
          mdio_oe <= 1'b1;
          mdio_o  <= frame[63];
          left    <= cmd_read ? 7'd45 : 7'd63;
          is_rd   <= cmd_read;
          rd_err  <= 1'b0;
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) mdc <= ~mdc;
        case (ph)
          SEND: if (fall) begin
            if (left == 0) begin
              mdio_oe <= 1'b0;
              mdio_o  <= 1'b0;
              if (is_rd) ph <= RELZ;
              else begin ph <= IDLE; done <= 1'b1; end
            end else begin
              sh     <= {sh[62:0], 1'b0};
              mdio_o <= sh[62];
              left   <= left - 1'b1;
            end
          end
          RELZ: if (rise) begin ph <= HUNT; hunt <= '0; end
          HUNT: if (rise) begin
            if (!mdio_i) begin
              ph <= CAPT; left <= 7'd15;
            end else if (hunt == HW'(WAIT_MAX - 1)) begin
              rd_err <= 1'b1; rd_data <= 16'hFFFF; ph <= FIN;
            end else hunt <= hunt + 1'b1;
          end
          CAPT: if (rise) begin
            rd_data <= {rd_data[14:0], mdio_i};
            if (left == 0) ph <= FIN;
            else left <= left - 1'b1;
          end
          FIN: if (fall) begin ph <= IDLE; done <= 1'b1; end
          default: ph <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rd_err,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        mdio_o
);
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));
  a_r8_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  a_r9_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  a_r7_err_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_err) |-> (rd_data == 16'hFFFF));
  a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_P = 10;
  localparam int HALF = 2;
  localparam int WMAX = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_read = 0;
  logic [4:0] cmd_phy = 0, cmd_reg = 0;
  logic [15:0] cmd_wdata = 0;
  logic busy, done, rd_err, mdc, mdio_oe, mdio_o;
  logic [15:0] rd_data;
  logic phy_oe = 0, phy_o = 0;
  wire line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.HALF(HALF), .WAIT_MAX(WMAX)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_read, .cmd_phy, .cmd_reg, .cmd_wdata,
    .busy, .done, .rd_data, .rd_err, .mdc, .mdio_oe, .mdio_o, .mdio_i(line));

  always #(CLK_P/2) clk = ~clk;

  int errs = 0, checks = 0;
  int nrise = 0, ndone = 0, conflict = 0, mdc_hi = 0, bad_half = 0;
  logic bits [1:90];
  logic oes [1:90];
  logic phy_rd = 0;
  int phy_d = 0;
  logic [15:0] phy_dat = 0;

  always @(posedge mdc) begin
    nrise = nrise + 1;
    if (nrise <= 90) begin bits[nrise] = line; oes[nrise] = mdio_oe; end
    if (mdio_oe && phy_oe) conflict = conflict + 1;
  end

  always @(negedge mdc) begin
    int nx;
    nx = nrise + 1;
    if (phy_rd && nx == 48 + phy_d) begin phy_oe = 1; phy_o = 0; end
    else if (phy_rd && nx > 48 + phy_d && nx <= 64 + phy_d) begin
      phy_oe = 1; phy_o = phy_dat[64 + phy_d - nx];
    end else phy_oe = 0;
  end

  always @(posedge clk) begin
    if (done) ndone <= ndone + 1;
    if (mdc) mdc_hi <= mdc_hi + 1;
    else begin
      if (mdc_hi != 0 && mdc_hi != HALF) bad_half <= bad_half + 1;
      mdc_hi <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(int i, bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] w);
    if (i <= 32) return 1'b1;
    if (i == 33) return 1'b0;
    if (i == 34) return 1'b1;
    if (i == 35) return rd;
    if (i == 36) return ~rd;
    if (i <= 41) return p[41 - i];
    if (i <= 46) return r[46 - i];
    if (i == 47) return 1'b1;
    if (i == 48) return 1'b0;
    return w[64 - i];
  endfunction

  task automatic run(input bit rd, input logic [4:0] p, input logic [4:0] r,
                     input logic [15:0] w, input int d, input bit inject);
    int nd, mism, oebad, d0, exp_n, wd;
    bit timeout;
    @(negedge clk);
    nrise = 0; phy_oe = 0; conflict = 0; d0 = ndone;
    phy_rd = rd; phy_d = d; phy_dat = w ^ 16'h5A3C;
    cmd_valid = 1; cmd_read = rd; cmd_phy = p; cmd_reg = r; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 0;
    if (inject) begin
      while (nrise < 20) @(negedge clk);
      cmd_valid = 1; cmd_read = ~rd; cmd_phy = ~p; cmd_reg = ~r; cmd_wdata = ~w;
      @(negedge clk);
      cmd_valid = 0;
      chk(busy, "R9", "busy after mid-frame command", busy, 1);
    end
    wd = 0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    timeout = rd && d >= WMAX;
    chk(done, "R9", "done seen", done, 1);
    if (rd) begin
      if (!timeout) begin
        chk(!rd_err && rd_data == (w ^ 16'h5A3C), "R6", "read data", rd_data, w ^ 16'h5A3C);
      end else begin
        chk(rd_err && rd_data == 16'hFFFF, "R7", "timeout data", rd_data, 16'hFFFF);
      end
    end
    repeat (4) @(negedge clk);
    exp_n = !rd ? 64 : (timeout ? 48 + WMAX - 1 : 64 + d);
    chk(nrise == exp_n, rd ? (timeout ? "R7" : "R6") : "R4", "MDC rising edges", nrise, exp_n);
    nd = rd ? 46 : 64;
    mism = 0; oebad = 0;
    for (int i = 1; i <= nd; i++) if (bits[i] !== exp_bit(i, rd, p, r, w)) mism++;
    for (int i = 1; i <= nrise && i <= 90; i++)
      if (oes[i] !== (i <= nd)) oebad++;
    chk(mism == 0, "R1/R2/R3", "frame bit mismatches", mism, 0);
    chk(oebad == 0, rd ? "R5" : "R4", "drive-enable pattern mismatches", oebad, 0);
    chk(conflict == 0, "R10", "line contention", conflict, 0);
    chk(ndone - d0 == 1, "R9", "done pulses", ndone - d0, 1);
    chk(!busy && !mdio_oe && !mdc, "R10", "idle line", mdio_oe, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [4:0] p;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R10", "reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      p = 5'(k * 6 + 1);
      run(0, p, 5'(k * 7 + 3), 16'(k * 16'h2B4D + 16'h8001), 0, 0);
      for (int d = 0; d <= WMAX; d++)
        run(1, p, 5'(31 - k * 5), 16'(k * 16'h1357 + d * 16'h0F0F), d, 0);
    end
    run(0, 5'd31, 5'd0, 16'hFFFF, 0, 0);
    run(1, 5'd0, 5'd31, 16'h0000, WMAX - 1, 0);
    run(0, 5'd9, 5'd18, 16'hC3A5, 0, 1);
    run(1, 5'd22, 5'd5, 16'h7E81, 1, 1);
    chk(bad_half == 0, "R8", "MDC high-phase length errors", bad_half, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule